// File: doc/BRIEF.md
# ECC Error Log and Fault-Injection Register Block

This block sits beside an ECC-protected on-chip SRAM and gives software a register window onto its error handling. The memory datapath reports each failing access with a one-cycle pulse, correctable or uncorrectable, together with the failing word offset, the 64-bit data word and its check bits. The block keeps a separate first-failure record for each error class. It also sets a write-one-to-clear status bit for the class and drives an interrupt line, which can be masked per class.

For testing the error path, the block holds a 64-bit flip pattern and a 24-bit countdown. Each memory write decrements a nonzero count. On the write that takes the count from one to zero, the block presents the pattern on `inj_flip`, and the datapath XORs it into the write data. A pattern with one set bit yields a correctable error on a later read. A pattern with two set bits yields an uncorrectable one. Register offsets are fixed because software decodes them. The reported failure address is the captured offset OR-ed with the memory base 0xFFFC0000.

Top module: `ecc_log_inj`

## Requirements
- R1: After reset, status (0x04) reads 0, the mask (0x08) reads 0xC0 with both classes masked, ECC control (0x14) reads 1, the count (0x74) and the pattern words read 0, and `irq` and `inj_flip` are 0.
- R2: A correctable pulse sets status bit 6. If that bit was clear, the pulse also records the failure: 0x1C reads 0xFFFC0000 OR the offset, 0x20 and 0x24 read data bits 31:0 and 63:32, and 0x30 reads the check bits. 0x28 and 0x2C read 0 at 64-bit width.
- R3: An uncorrectable pulse sets status bit 7 and records into the second set: address at 0x34, data at 0x38 and 0x3C, check bits at 0x48.
- R4: While a class's status bit is set, further pulses of that class leave its record unchanged.
- R5: Writing 1 to status bit 6 or 7 at 0x04 clears that bit. A write of 0 leaves it unchanged. After a clear, the next pulse records afresh.
- R6: Writing 1s to bits 7:6 at 0x0C clears the matching mask bits. Writing them at 0x10 sets the mask bits. `irq` is the OR of the status bits whose mask bit is 0.
- R7: Bit 0 of 0x14 is read/write and is driven on `ecc_on`. While it is 0, error pulses set no status and record nothing.
- R8: The flip pattern reads back with bits 31:0 at 0x4C and bits 63:32 at 0x50.
- R9: A write to 0x74 keeps only bits 23:0, and 0x74 reads the current count.
- R10: A `mem_wr` cycle decrements a nonzero count. `inj_flip` equals the pattern during the write cycle that moves the count from 1 to 0, and is 0 in every other cycle. Once the count is 0 it stays 0 until rewritten.
- R11: Reads of unmapped offsets, including 0x0C, 0x10, 0x18, 0x54 and 0x60, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; data is valid the next cycle |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ecc_on | output | 1 | ECC checking enable to the datapath |
| err_ce | input | 1 | Correctable error pulse |
| err_ue | input | 1 | Uncorrectable error pulse |
| err_ofs | input | OFS_W | Failing word offset |
| err_data | input | DATA_W | Failing data word |
| err_chk | input | CHK_W | Failing check bits |
| mem_wr | input | 1 | Memory write in progress this cycle |
| inj_flip | output | DATA_W | Mask XORed into write data |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume that `err_ce`, `err_ue` and `mem_wr` are clean single-cycle levels sampled at the clock. They also assume that a bus write to the count and a memory write may coincide, with the bus write taking effect, which is why the counter properties exclude that cycle. The stimulus drives each error pulse, bus access and memory write for exactly one cycle, with inputs changed away from the rising edge. It never overlaps a status clear with a pulse of the same class, so the record and hold checks see a single cause per cycle.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   // Register byte offsets; software decodes these
   localparam int OFF_STAT    = 32'h04;
   localparam int OFF_MASK    = 32'h08;
   localparam int OFF_IEN     = 32'h0C;
   localparam int OFF_IDS     = 32'h10;
   localparam int OFF_CTRL    = 32'h14;
   localparam int OFF_CE_BASE = 32'h1C;
   localparam int OFF_UE_BASE = 32'h34;
   localparam int OFF_PAT     = 32'h4C;
   localparam int OFF_FCNT    = 32'h74;

   // Layout inside one capture set, relative to its base
   localparam int CAP_DATA_REL = 4;
   localparam int CAP_CHK_REL  = 32'h14;
   localparam int CAP_SLOTS    = 4;

   // Status / mask bit positions
   localparam int BIT_CE = 6;
   localparam int BIT_UE = 7;
   localparam int KINDS  = 2;

   typedef enum logic {KIND_CE = 1'b0, KIND_UE = 1'b1} err_kind_e;

   function automatic int cap_base(input int k);
      return (k == int'(KIND_CE)) ? OFF_CE_BASE : OFF_UE_BASE;
   endfunction
endpackage

// File: rtl/ecc_capture.sv
module ecc_capture #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   parameter int OFS_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              clr,
   input  logic [OFS_W-1:0]  err_ofs,
   input  logic [DATA_W-1:0] err_data,
   input  logic [CHK_W-1:0]  err_chk,
   output logic              flag,
   output logic [OFS_W-1:0]  ofs_q,
   output logic [DATA_W-1:0] data_q,
   output logic [CHK_W-1:0]  chk_q
);
   logic load;
   assign load = hit && !flag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hit) begin
         flag <= 1'b1;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs_q  <= '0;
         data_q <= '0;
         chk_q  <= '0;
      end else if (load) begin
         ofs_q  <= err_ofs;
         data_q <= err_data;
         chk_q  <= err_chk;
      end
   end

   // R2 / R3: a qualified pulse always leaves the status bit set
   assert_pulse_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);

   // R4: a set status bit freezes the record
   assert_first_failure_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flag |=> ($stable(data_q) && $stable(ofs_q) && $stable(chk_q)));
endmodule

// File: rtl/ecc_inject.sv
module ecc_inject #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W/32-1:0] pat_we,
   input  logic                 cnt_we,
   input  logic [31:0]          wdata,
   input  logic                 mem_wr,
   output logic [DATA_W-1:0]    pat,
   output logic [CNT_W-1:0]     cnt,
   output logic [DATA_W-1:0]    flip
);
   localparam int NWORDS = DATA_W / 32;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   genvar w;
   generate
      for (w = 0; w < NWORDS; w++) begin : g_pat
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pat[32*w +: 32] <= '0;
            end else if (pat_we[w]) begin
               pat[32*w +: 32] <= wdata;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt_we) begin
         cnt <= wdata[CNT_W-1:0];
      end else if (mem_wr && (cnt != '0)) begin
         cnt <= cnt - CNT_ONE;
      end
   end

   assign flip = (mem_wr && (cnt == CNT_ONE)) ? pat : '0;

   // R10: each memory write steps a live count down by one
   assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && (cnt != '0) && !cnt_we) |=> (cnt == $past(cnt) - CNT_ONE));

   // R10: an applied flip leaves the counter spent
   assert_single_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((flip != '0) && !cnt_we) |=> (cnt == '0));
endmodule

// File: rtl/ecc_log_inj.sv
module ecc_log_inj
   import ecc_log_pkg::*;
#(
   parameter int          DATA_W     = 64,
   parameter int          CHK_W      = 8,
   parameter int          OFS_W      = 18,
   parameter int          CNT_W      = 24,
   parameter int          REG_AW     = 8,
   parameter logic [31:0] MEM_BASE   = 32'hFFFC0000,
   parameter bit          ECC_ON_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              ecc_on,
   input  logic              err_ce,
   input  logic              err_ue,
   input  logic [OFS_W-1:0]  err_ofs,
   input  logic [DATA_W-1:0] err_data,
   input  logic [CHK_W-1:0]  err_chk,
   input  logic              mem_wr,
   output logic [DATA_W-1:0] inj_flip,
   output logic              irq
);
   localparam int NWORDS = DATA_W / 32;

   generate
      if ((DATA_W % 32) != 0 || DATA_W < 32 || DATA_W > 32 * CAP_SLOTS) begin : g_bad_data_w
         $error("DATA_W must be 32, 64, 96 or 128");
      end
      if (CHK_W < 1 || CHK_W > 32) begin : g_bad_chk_w
         $error("CHK_W must be 1..32");
      end
      if (OFS_W < 1 || OFS_W > 32) begin : g_bad_ofs_w
         $error("OFS_W must be 1..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("CNT_W must be 1..32");
      end
      if (REG_AW < 7 || REG_AW > 32) begin : g_bad_reg_aw
         $error("REG_AW must cover offset 0x74");
      end
   endgenerate

   logic [31:0] addr32;
   assign addr32 = 32'(reg_addr);

   // Write decode
   logic we_stat, we_ien, we_ids, we_ctrl, we_cnt;
   logic [NWORDS-1:0] we_pat;
   assign we_stat = reg_wr_en && (addr32 == OFF_STAT);
   assign we_ien  = reg_wr_en && (addr32 == OFF_IEN);
   assign we_ids  = reg_wr_en && (addr32 == OFF_IDS);
   assign we_ctrl = reg_wr_en && (addr32 == OFF_CTRL);
   assign we_cnt  = reg_wr_en && (addr32 == OFF_FCNT);

   always_comb begin
      for (int w = 0; w < NWORDS; w++) begin
         we_pat[w] = reg_wr_en && (addr32 == OFF_PAT + 4 * w);
      end
   end

   // ECC enable
   logic ecc_on_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ecc_on_q <= ECC_ON_RST;
      end else if (we_ctrl) begin
         ecc_on_q <= reg_wdata[0];
      end
   end
   assign ecc_on = ecc_on_q;

   // Interrupt mask, 1 = masked, index 0 = CE, 1 = UE
   logic [KINDS-1:0] mask_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (we_ien) begin
         mask_q <= mask_q & ~reg_wdata[BIT_UE:BIT_CE];
      end else if (we_ids) begin
         mask_q <= mask_q | reg_wdata[BIT_UE:BIT_CE];
      end
   end

   // Capture sets
   logic [KINDS-1:0]  stat, hits, clrs;
   logic [OFS_W-1:0]  cap_ofs  [KINDS];
   logic [DATA_W-1:0] cap_data [KINDS];
   logic [CHK_W-1:0]  cap_chk  [KINDS];

   assign hits[KIND_CE] = err_ce && ecc_on_q;
   assign hits[KIND_UE] = err_ue && ecc_on_q;
   assign clrs = we_stat ? reg_wdata[BIT_UE:BIT_CE] : '0;

   genvar k;
   generate
      for (k = 0; k < KINDS; k++) begin : g_cap
         ecc_capture #(
            .DATA_W (DATA_W),
            .CHK_W  (CHK_W),
            .OFS_W  (OFS_W)
         ) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hits[k]),
            .clr      (clrs[k]),
            .err_ofs  (err_ofs),
            .err_data (err_data),
            .err_chk  (err_chk),
            .flag     (stat[k]),
            .ofs_q    (cap_ofs[k]),
            .data_q   (cap_data[k]),
            .chk_q    (cap_chk[k])
         );
      end
   endgenerate

   // Fault injection
   logic [DATA_W-1:0] pat;
   logic [CNT_W-1:0]  cnt;

   ecc_inject #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_inj (
      .clk    (clk),
      .rst_n  (rst_n),
      .pat_we (we_pat),
      .cnt_we (we_cnt),
      .wdata  (reg_wdata),
      .mem_wr (mem_wr),
      .pat    (pat),
      .cnt    (cnt),
      .flip   (inj_flip)
   );

   assign irq = |(stat & ~mask_q);

   // Read mux
   logic [31:0] rd_d;
   always_comb begin
      rd_d = '0;
      case (addr32)
         OFF_STAT: rd_d[BIT_UE:BIT_CE] = stat;
         OFF_MASK: rd_d[BIT_UE:BIT_CE] = mask_q;
         OFF_CTRL: rd_d[0]             = ecc_on_q;
         OFF_FCNT: rd_d                = 32'(cnt);
         default:  rd_d                = '0;
      endcase
      for (int c = 0; c < KINDS; c++) begin
         if (addr32 == cap_base(c)) begin
            rd_d = MEM_BASE | 32'(cap_ofs[c]);
         end
         for (int s = 0; s < NWORDS; s++) begin
            if (addr32 == cap_base(c) + CAP_DATA_REL + 4 * s) begin
               rd_d = cap_data[c][32*s +: 32];
            end
         end
         if (addr32 == cap_base(c) + CAP_CHK_REL) begin
            rd_d = 32'(cap_chk[c]);
         end
      end
      for (int w = 0; w < NWORDS; w++) begin
         if (addr32 == OFF_PAT + 4 * w) begin
            rd_d = pat[32*w +: 32];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd_en) begin
         reg_rdata <= rd_d;
      end
   end

   // R7: with checking off, clear status stays clear
   assert_pulses_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ecc_on_q && (stat == '0)) |=> (stat == '0));
endmodule

// File: tb/test_ecc_log_inj.sv
module test_ecc_log_inj;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr_en, reg_rd_en;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        ecc_on;
   logic        err_ce, err_ue;
   logic [17:0] err_ofs;
   logic [63:0] err_data;
   logic [7:0]  err_chk;
   logic        mem_wr;
   logic [63:0] inj_flip;
   logic        irq;

   always #5 clk = ~clk;

   ecc_log_inj i_ecc_log_inj (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ecc_on(ecc_on),
      .err_ce(err_ce), .err_ue(err_ue), .err_ofs(err_ofs),
      .err_data(err_data), .err_chk(err_chk),
      .mem_wr(mem_wr), .inj_flip(inj_flip), .irq(irq)
   );

   int n_vec = 0;
   int n_bad = 0;
   logic [31:0] q_exp [$];
   string       q_tag [$];
   logic        rd_seen = 1'b0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: a read launched at a rising edge is compared at the next falling edge
   always @(posedge clk) rd_seen <= reg_rd_en;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (q_exp.size() == 0) begin
            check("scoreboard underrun", 64'(reg_rdata), 64'hX);
         end else begin
            check(q_tag.pop_front(), 64'(reg_rdata), 64'(q_exp.pop_front()));
         end
      end
   end

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      reg_rd_en = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd_en = 1'b0;
   endtask

   task automatic err_pulse(input logic ce, input logic ue, input logic [17:0] o,
                            input logic [63:0] d, input logic [7:0] c);
      err_ce = ce; err_ue = ue; err_ofs = o; err_data = d; err_chk = c;
      @(negedge clk);
      err_ce = 1'b0; err_ue = 1'b0;
   endtask

   task automatic mem_write(input logic [63:0] exp_flip, input string tag);
      mem_wr = 1'b1;
      #1;
      check(tag, inj_flip, exp_flip);
      @(negedge clk);
      mem_wr = 1'b0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = '0; reg_wdata = '0;
      err_ce = 0; err_ue = 0; err_ofs = '0; err_data = '0; err_chk = '0; mem_wr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", 64'(irq), 64'd0);
      check("R1 flip", inj_flip, 64'd0);
      check("R1 ecc_on", 64'(ecc_on), 64'd1);
      bus_rd(8'h04, 32'h0, "R1 status");
      bus_rd(8'h08, 32'hC0, "R1 mask");
      bus_rd(8'h14, 32'h1, "R1 ctrl");
      bus_rd(8'h74, 32'h0, "R1 count");
      bus_rd(8'h4C, 32'h0, "R1 pattern");

      // R2 correctable capture
      err_pulse(1, 0, 18'h01234, 64'hDEADBEEF_01234567, 8'h5A);
      bus_rd(8'h04, 32'h40, "R2 status");
      check("R2 irq masked", 64'(irq), 64'd0);
      bus_rd(8'h1C, 32'hFFFC1234, "R2 address");
      bus_rd(8'h20, 32'h01234567, "R2 data low");
      bus_rd(8'h24, 32'hDEADBEEF, "R2 data high");
      bus_rd(8'h28, 32'h0, "R2 slot2 zero");
      bus_rd(8'h30, 32'h5A, "R2 check bits");

      // R4 hold first failure
      err_pulse(1, 0, 18'h3FFFF, 64'h11112222_33334444, 8'hA5);
      bus_rd(8'h1C, 32'hFFFC1234, "R4 address held");
      bus_rd(8'h20, 32'h01234567, "R4 data held");
      bus_rd(8'h30, 32'h5A, "R4 check held");

      // R6 mask enable / disable
      bus_wr(8'h0C, 32'h40);
      bus_rd(8'h08, 32'h80, "R6 mask after enable CE");
      check("R6 irq unmasked", 64'(irq), 64'd1);
      bus_wr(8'h10, 32'h40);
      bus_rd(8'h08, 32'hC0, "R6 mask after disable");
      check("R6 irq masked again", 64'(irq), 64'd0);
      bus_wr(8'h0C, 32'hC0);
      bus_rd(8'h08, 32'h0, "R6 mask all open");
      check("R6 irq open", 64'(irq), 64'd1);

      // R5 write-one-to-clear
      bus_wr(8'h04, 32'h0);
      bus_rd(8'h04, 32'h40, "R5 zero write ignored");
      bus_wr(8'h04, 32'h40);
      bus_rd(8'h04, 32'h0, "R5 cleared");
      check("R5 irq after clear", 64'(irq), 64'd0);

      // R3 uncorrectable capture, and R5 fresh CE record at top offset
      err_pulse(0, 1, 18'h00010, 64'h0F0F0F0F_F0F0F0F0, 8'h33);
      check("R3 irq", 64'(irq), 64'd1);
      bus_rd(8'h04, 32'h80, "R3 status");
      bus_rd(8'h34, 32'hFFFC0010, "R3 address");
      bus_rd(8'h38, 32'hF0F0F0F0, "R3 data low");
      bus_rd(8'h3C, 32'h0F0F0F0F, "R3 data high");
      bus_rd(8'h48, 32'h33, "R3 check bits");
      err_pulse(1, 0, 18'h3FFFF, 64'h0, 8'h01);
      bus_rd(8'h1C, 32'hFFFFFFFF, "R5 new CE record");
      bus_wr(8'h04, 32'hC0);
      bus_rd(8'h04, 32'h0, "R5 both cleared");

      // R7 checking disabled
      bus_wr(8'h14, 32'h0);
      bus_rd(8'h14, 32'h0, "R7 ctrl readback");
      check("R7 ecc_on low", 64'(ecc_on), 64'd0);
      err_pulse(1, 1, 18'h00777, 64'hFFFF, 8'hFF);
      bus_rd(8'h04, 32'h0, "R7 pulses ignored");
      bus_rd(8'h34, 32'hFFFC0010, "R7 UE record untouched");
      check("R7 irq", 64'(irq), 64'd0);
      bus_wr(8'h14, 32'h1);

      // R8 pattern, R9 count
      bus_wr(8'h4C, 32'h00000001);
      bus_wr(8'h50, 32'h80000000);
      bus_rd(8'h4C, 32'h00000001, "R8 pattern low");
      bus_rd(8'h50, 32'h80000000, "R8 pattern high");
      bus_wr(8'h74, 32'hFF000003);
      bus_rd(8'h74, 32'h00000003, "R9 count truncated");

      // R10 countdown and single shot
      mem_write(64'h0, "R10 write 1 no flip");
      mem_write(64'h0, "R10 write 2 no flip");
      bus_rd(8'h74, 32'h1, "R10 count at one");
      mem_write(64'h80000000_00000001, "R10 flip applied");
      bus_rd(8'h74, 32'h0, "R10 count spent");
      mem_write(64'h0, "R10 no second flip");
      bus_rd(8'h74, 32'h0, "R10 count stays zero");

      // R11 unmapped offsets
      bus_rd(8'h0C, 32'h0, "R11 enable reg reads zero");
      bus_rd(8'h10, 32'h0, "R11 disable reg reads zero");
      bus_rd(8'h18, 32'h0, "R11 0x18");
      bus_rd(8'h54, 32'h0, "R11 0x54");
      bus_rd(8'h60, 32'h0, "R11 0x60");

      repeat (2) @(negedge clk);
      if (q_exp.size() != 0) check("scoreboard leftover", 64'(q_exp.size()), 64'd0);
      summary();
      $finish;
   end
endmodule